// File: doc/BRIEF.md
# Epoch Token Count Predictor

At each epoch boundary this block decides how many transmit tokens, meaning shared channels that will carry power, are issued for the next epoch. It has its own epoch timer. On the last cycle of every epoch it samples two inputs. The first is a set of small per-station counts of requests sent toward the off-chip gateways. The second is a set of per-gateway pending-queue readings. It adds each set into a single total.

A prediction table holds 4-bit entries. It is indexed by the request total of the epoch before. The entry it reads is adjusted in one of three ways, chosen by how high the pending total stands against two thresholds. The middle band also compares the current request total with the previous one. The table is trained only in the lowest and the highest pressure bands. The result is clamped to the legal token range and registered, and it is announced with a one-cycle done strobe.

Laser power, splitter settings and any optical control lie outside the block. It produces only the token count.

Top module: `epoch_token_predictor`

## Requirements
- R1: The request total C is the sum of sixteen 2-bit fields, with station i at bits [2i+1:2i] of `stn_req_cnt`. The pending total P is the sum of four 4-bit fields, with gateway j at bits [4j+3:4j] of `q_pend`.
- R2: An epoch lasts 100 cycles. `done` is high for exactly one cycle per epoch, so consecutive pulses are exactly 100 cycles apart.
- R3: During reset, `token_count` reads 4 and `done` reads 0. Every one of the 64 table entries starts at 4, which is half the maximum of 8 tokens.
- R4: The first epoch after reset has no previous total. It yields 4 tokens and leaves the table untouched.
- R5: When P < 16, the result is entry[C_prev] − 1 and that entry is decremented.
- R6: When P ≥ 32, the result is entry[C_prev] + 1 and that entry is incremented.
- R7: When 16 ≤ P < 32, the result is entry[C_prev] − 1 if C < C_prev, and entry[C_prev] otherwise. The table is not written.
- R8: The token count is always clamped to the range 1 to 8.
- R9: A table entry saturates: it never falls below 0 and never rises above 15.
- R10: `token_count` changes only in the cycle in which `done` is high, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stn_req_cnt | input | 32 | Sixteen 2-bit per-station request counts |
| q_pend | input | 16 | Four 4-bit per-gateway pending-queue values |
| token_count | output | 4 | Tokens granted for the next epoch |
| done | output | 1 | One-cycle strobe that marks a new token count |

## Verification
The inputs are sampled on the last cycle of an epoch, which is the 100th cycle after reset release or after the previous boundary. The totals are registered on that edge. The decision and the table write take effect one edge later, so `token_count` and `done` are valid during the second cycle after the boundary. The bench waits on falling edges until `done` appears and compares the token count in that cycle. It then checks that `done` has dropped on the next falling edge, and only after that does it drive the next epoch's inputs, about 98 cycles before the next capture. The spacing between pulses is measured with a free-running cycle count and must equal 100.

// File: rtl/etp_pkg.sv
// Shared types for the epoch token predictor.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package etp_pkg;
    // Pressure band of the pending total, relative to the two thresholds
    typedef enum logic [1:0] {
        BAND_LOW  = 2'd0,
        BAND_MID  = 2'd1,
        BAND_HIGH = 2'd2
    } band_e;
endpackage

// File: rtl/etp_epoch_timer.sv
// Free-running epoch timer. It raises tick on the last cycle of each epoch.
// Assumes: EPOCH_LEN >= 2, and the count restarts at zero on reset.
module etp_epoch_timer #(
    parameter int EPOCH_LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(EPOCH_LEN);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == CNT_W'(EPOCH_LEN - 1));

    // Count through one epoch, then wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/etp_field_sum.sv
// Adds N unsigned fields of W bits, packed side by side, into one total.
// Assumes: SUM_W is wide enough to hold N*(2**W-1).
module etp_field_sum #(
    parameter int N     = 16,
    parameter int W     = 2,
    parameter int SUM_W = 6
) (
    input  logic [N*W-1:0] vec,
    output logic [SUM_W-1:0] sum
);
    // Accumulate every field
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + SUM_W'(vec[i*W +: W]);
        end
    end
endmodule

// File: rtl/etp_pred_table.sv
// Prediction table with one asynchronous read port and one synchronous write port.
// On reset every entry is loaded with INIT.
// Assumes: at most one write per cycle.
module etp_pred_table #(
    parameter int IDX_W = 6,
    parameter int ENT_W = 4,
    parameter int INIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data
);
    localparam int DEPTH = 2 ** IDX_W;

    logic [ENT_W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each entry loads INIT on reset and otherwise takes a write aimed at it
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= ENT_W'(INIT);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ent_q[g] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/epoch_token_predictor.sv
// Epoch token predictor.
// On the last cycle of each epoch it samples the station request counts and
// the pending-queue values. It adds each set, then (one cycle later) reads the
// table entry chosen by the previous epoch's request total, picks the result by
// pressure band, trains the table in the outer bands, and registers the clamped
// token count together with a one-cycle done strobe.
// Assumes: the inputs are stable on the boundary cycle.
module epoch_token_predictor
    import etp_pkg::*;
#(
    parameter int N_STN     = 16,
    parameter int STN_W     = 2,
    parameter int N_Q       = 4,
    parameter int Q_W       = 4,
    parameter int ENT_W     = 4,
    parameter int MAX_TOK   = 8,
    parameter int EPOCH_LEN = 100,
    parameter int P_LO      = 16,
    parameter int P_HI      = 32,
    localparam int TOK_W    = $clog2(MAX_TOK + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_STN*STN_W-1:0] stn_req_cnt,
    input  logic [N_Q*Q_W-1:0]     q_pend,
    output logic [TOK_W-1:0]       token_count,
    output logic                   done
);
    localparam int C_W      = $clog2(N_STN * (2 ** STN_W - 1) + 1);
    localparam int P_W      = $clog2(N_Q * (2 ** Q_W - 1) + 1);
    localparam int ENT_MAX  = 2 ** ENT_W - 1;
    localparam int INIT_TOK = MAX_TOK / 2;

    logic             tick;
    logic [C_W-1:0]   c_sum;
    logic [P_W-1:0]   p_sum;

    // Stage 1: sampled totals
    logic             s1_vld;
    logic [C_W-1:0]   c_cur_q;
    logic [P_W-1:0]   p_q;

    // Stage 2: result and history
    logic [TOK_W-1:0] token_q;
    logic             done_q;
    logic [C_W-1:0]   c_prev_q;
    logic             have_prev_q;

    logic [ENT_W-1:0] ent, ent_dn, ent_up, ent_raw, wr_data;
    logic             wr_en;
    band_e            band;
    logic [TOK_W-1:0] tok_nxt;

    etp_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    etp_field_sum #(.N(N_STN), .W(STN_W), .SUM_W(C_W)) i_c_sum (
        .vec(stn_req_cnt),
        .sum(c_sum)
    );

    etp_field_sum #(.N(N_Q), .W(Q_W), .SUM_W(P_W)) i_p_sum (
        .vec(q_pend),
        .sum(p_sum)
    );

    etp_pred_table #(.IDX_W(C_W), .ENT_W(ENT_W), .INIT(INIT_TOK)) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (c_prev_q),
        .rd_data(ent),
        .wr_en  (wr_en),
        .wr_idx (c_prev_q),
        .wr_data(wr_data)
    );

    // Capture both totals on the epoch boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            c_cur_q <= '0;
            p_q     <= '0;
        end else begin
            s1_vld <= tick;
            if (tick) begin
                c_cur_q <= c_sum;
                p_q     <= p_sum;
            end
        end
    end

    // Classify the pending total against the two thresholds
    always_comb begin
        if (int'(p_q) < P_LO)       band = BAND_LOW;
        else if (int'(p_q) >= P_HI) band = BAND_HIGH;
        else                        band = BAND_MID;
    end

    // Pick the raw prediction, its clamped token count and the table update
    always_comb begin
        ent_dn = (ent == '0) ? ent : ent - 1'b1;
        ent_up = (ent == ENT_W'(ENT_MAX)) ? ent : ent + 1'b1;
        unique case (band)
            BAND_LOW:  ent_raw = ent_dn;
            BAND_HIGH: ent_raw = ent_up;
            default:   ent_raw = (c_cur_q < c_prev_q) ? ent_dn : ent;
        endcase
        if (!have_prev_q)                tok_nxt = TOK_W'(INIT_TOK);
        else if (int'(ent_raw) < 1)      tok_nxt = TOK_W'(1);
        else if (int'(ent_raw) > MAX_TOK) tok_nxt = TOK_W'(MAX_TOK);
        else                             tok_nxt = TOK_W'(ent_raw);
        wr_en   = s1_vld && have_prev_q && (band != BAND_MID);
        wr_data = (band == BAND_LOW) ? ent_dn : ent_up;
    end

    // Register the result, pulse done, and keep the current total as history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token_q     <= TOK_W'(INIT_TOK);
            done_q      <= 1'b0;
            c_prev_q    <= '0;
            have_prev_q <= 1'b0;
        end else begin
            done_q <= s1_vld;
            if (s1_vld) begin
                token_q     <= tok_nxt;
                c_prev_q    <= c_cur_q;
                have_prev_q <= 1'b1;
            end
        end
    end

    assign token_count = token_q;
    assign done        = done_q;
endmodule

// File: rtl/etp_checker.sv
// Property checker for the epoch token predictor. It is bound to the top module.
// Assumes: the same reset and clock as the design.
module etp_checker #(
    parameter int MAX_TOK   = 8,
    parameter int EPOCH_LEN = 100,
    parameter int TOK_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [TOK_W-1:0] token_count,
    input logic             s1_vld
);
    localparam int GAP_W = $clog2(EPOCH_LEN) + 2;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Count the cycles since the last done pulse, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (done) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: pulses are exactly one epoch apart
    p_done_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen_q) |-> (gap_q == GAP_W'(EPOCH_LEN - 1)));

    // R2: a captured boundary yields done on the next cycle
    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> done);

    // R8: token count inside 1..MAX_TOK whenever it is announced
    p_token_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (token_count >= TOK_W'(1) && token_count <= TOK_W'(MAX_TOK)));

    // R10: token count holds outside done cycles
    p_token_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(token_count));
endmodule

bind epoch_token_predictor etp_checker #(
    .MAX_TOK  (MAX_TOK),
    .EPOCH_LEN(EPOCH_LEN),
    .TOK_W    (TOK_W)
) i_etp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .token_count(token_count),
    .s1_vld     (s1_vld)
);

// File: tb/test_epoch_token_predictor.sv
`timescale 1ns/1ps
// Directed bench for the epoch token predictor. It keeps its own table model
// built from the requirements.
module test_epoch_token_predictor;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] stn;
    logic [15:0] pnd;
    logic [3:0]  tok;
    logic        done;

    int      total = 0;
    int      bad   = 0;
    int      mdl [64];
    int      prev_c;
    bit      first;
    int      last_tok;
    longint  cyc = 0;
    longint  last_done = -1;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    epoch_token_predictor i_epoch_token_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .stn_req_cnt(stn),
        .q_pend     (pnd),
        .token_count(tok),
        .done       (done)
    );

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sum_stn(input logic [31:0] v);
        int s = 0;
        for (int i = 0; i < 16; i++) s += int'(v[2*i +: 2]);
        return s;
    endfunction

    function automatic int sum_pnd(input logic [15:0] v);
        int s = 0;
        for (int j = 0; j < 4; j++) s += int'(v[4*j +: 4]);
        return s;
    endfunction

    function automatic logic [31:0] mk_stn(input int c);
        logic [31:0] v = '0;
        int rest = c;
        for (int i = 0; i < 16; i++) begin
            int take = (rest > 3) ? 3 : rest;
            v[2*i +: 2] = 2'(take);
            rest -= take;
        end
        return v;
    endfunction

    function automatic logic [15:0] mk_pnd(input int p);
        logic [15:0] v = '0;
        int rest = p;
        for (int j = 0; j < 4; j++) begin
            int take = (rest > 15) ? 15 : rest;
            v[4*j +: 4] = 4'(take);
            rest -= take;
        end
        return v;
    endfunction

    // R3: reset values seen at the outputs
    task automatic t_reset();
        rst_n = 1'b0;
        stn   = '0;
        pnd   = '0;
        repeat (3) @(negedge clk);
        check_eq("R3", "token during reset", tok, 4);
        check_eq("R3", "done during reset", done, 0);
        for (int i = 0; i < 64; i++) mdl[i] = 4;  // R3: every entry starts at 4
        first    = 1'b1;
        prev_c   = 0;
        last_tok = 4;
        rst_n    = 1'b1;
    endtask

    // One epoch: drive inputs, predict, wait for done, check result and timing
    task automatic run_epoch(input logic [31:0] s, input logic [15:0] pd, input string req);
        int  c, p, e, exp;
        int  waited = 0;
        bit  held   = 1'b1;
        stn = s;
        pnd = pd;
        c = sum_stn(s);  // R1
        p = sum_pnd(pd); // R1
        if (first) begin
            exp = 4;     // R4
        end else begin
            e = mdl[prev_c];
            if (p < 16) begin          // R5
                exp = e - 1;
                mdl[prev_c] = (e > 0) ? e - 1 : 0;   // R9
            end else if (p >= 32) begin // R6
                exp = e + 1;
                mdl[prev_c] = (e < 15) ? e + 1 : 15; // R9
            end else begin             // R7
                exp = (c < prev_c) ? e - 1 : e;
            end
            if (exp < 1) exp = 1;      // R8
            if (exp > 8) exp = 8;      // R8
        end
        prev_c = c;
        first  = 1'b0;
        while (!done && waited < 300) begin
            if (tok != 4'(last_tok)) held = 1'b0;
            @(negedge clk);
            waited++;
        end
        check_eq("R2", "done arrived", done, 1);
        check_eq("R10", "token held between pulses", held, 1);
        check_eq(req, "token count", tok, exp);
        last_tok = int'(tok);
        if (last_done >= 0) check_eq("R2", "cycles between done pulses", cyc - last_done, 100);
        last_done = cyc;
        @(negedge clk);
        check_eq("R2", "done single cycle", done, 0);
    endtask

    // R4: first epoch returns the initial value
    task automatic t_first();
        run_epoch(mk_stn(10), mk_pnd(0), "R4");
    endtask

    // R5, R8, R9: low pressure walks one entry down to the floor
    task automatic t_low();
        for (int k = 0; k < 6; k++) run_epoch(mk_stn(10), mk_pnd(0), "R5_R8_R9");
    endtask

    // R6, R8, R9: high pressure walks entries up to the ceiling
    task automatic t_high();
        for (int k = 0; k < 14; k++) run_epoch(mk_stn(48), mk_pnd(60), "R6_R8_R9");
    endtask

    // R7: middle band, both orderings of the totals, and the table left intact
    task automatic t_mid();
        run_epoch(mk_stn(7), mk_pnd(20), "R7");
        run_epoch(mk_stn(9), mk_pnd(16), "R7");
        run_epoch(mk_stn(3), mk_pnd(31), "R7");
        run_epoch(mk_stn(9), mk_pnd(20), "R7");
        run_epoch(mk_stn(9), mk_pnd(20), "R7");
    endtask

    // R5, R6: the threshold edges 15 and 32
    task automatic t_edges();
        run_epoch(mk_stn(9), mk_pnd(15), "R5");
        run_epoch(mk_stn(9), mk_pnd(32), "R6");
    endtask

    // R1: uneven field patterns on both inputs
    task automatic t_fields();
        run_epoch(32'h0000_00E4, 16'hF100, "R1");
        run_epoch(32'h3333_3333, 16'h0F0F, "R1");
        run_epoch(32'hC000_0003, 16'h8888, "R1");
        run_epoch(32'h0000_0040, 16'h0000, "R1");
        run_epoch(32'h0000_0040, 16'h1000, "R1");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_first();
        t_low();
        t_high();
        t_mid();
        t_edges();
        t_fields();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule